// File: doc/BRIEF.md
# Banked CMOS Register Port with Flag Interrupt

This block is the host-facing side of a clock/CMOS device. A byte-wide host bus with a two-bit address reaches a 256-byte store through two index registers, one per 128-byte half. The first fourteen locations of the low half carry special behaviour: control bytes with protected bits, two locations the host cannot alter, a flag byte that clears itself when read, and time/date bytes whose writes hand a reload request to a separate counting engine. That engine is not part of this block. It talks to the port through a small update interface: it can mark an update as in progress, copy fresh time bytes back, and report periodic, alarm and update-ended events.

Events that are enabled in the control byte set bits in the flag byte and raise a level interrupt. An interrupt state machine has two states, `IRQ_QUIET` and `IRQ_RAISED`. It takes the transition *raise* (QUIET to RAISED) when an enabled event arrives while the suppress input is low. It takes the transition *acknowledge* (RAISED to QUIET) when the host reads the flag byte and no new unsuppressed event arrives in the same cycle. In every other case it holds its state.

Top module: `cmos_host_port`

## Requirements
- R1: `addr[1]` selects bank 0 or bank 1, and `addr[0]` selects the index port (0) or the data port (1). An index write stores `wdata[6:0]`, with 128 added for bank 1. Data-port accesses reach the byte at that bank's index.
- R2: A read of either index port returns 0xFF. All read data appears on `rd_data` in the cycle after `rd_en`.
- R3: After reset, byte 10 reads 0x26, byte 11 reads 0x02, byte 12 reads 0x00, byte 13 reads 0x80, and `irq` is low.
- R4: Host writes to byte 12 (flags) and byte 13 leave them unchanged.
- R5: A host write to byte 10 takes bits 6:0 from the data and keeps the current update-in-progress bit (bit 7).
- R6: A write to byte 11 with bit 7 (freeze) set clears bit 7 of byte 10.
- R7: A write to byte 11 with bit 7 clear, while the stored bit 7 was set, pulses `ctr_load` for one cycle. It gives no pulse if freeze was already clear.
- R8: A host write to a time byte (0, 2, 4, 6, 7, 8, 9) is stored and pulses `ctr_load` unless freeze is set. Alarm bytes 1, 3 and 5 never pulse it. `ctr_time` presents bytes {9,8,7,6,4,2,0} from high to low.
- R9: `upd_start` sets bit 7 of byte 10 only when freeze is clear, and `upd_end` clears it. `upd_wr` stores `upd_data` into time byte `upd_idx` only when freeze is clear.
- R10: `evt_periodic` with byte 11 bit 6 set ORs 0xC0 into the flags, `evt_alarm` with bit 5 ORs in 0xA0, and `evt_update` with bit 4 ORs in 0x90. An event whose enable is clear changes nothing.
- R11: `irq` rises in the cycle after an enabled event and stays high until the flags are read. That read returns the flags, clears them to 0x00 and lowers `irq`.
- R12: While `irq_suppress` is high, enabled events still set flags but do not raise `irq`.
- R13: When a flag read and an enabled event fall in the same cycle, the read returns the old flags, the flags afterwards hold only the new event's bits, and `irq` is high.
- R14: Bank 1 locations, including index 140, are plain storage with no read or write side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Bit 1 bank, bit 0 index/data select |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rd_data | output | 8 | Host read data, registered |
| upd_start | input | 1 | Counter begins an update |
| upd_end | input | 1 | Counter finished an update |
| upd_wr | input | 1 | Counter copies a time byte back |
| upd_idx | input | 4 | Time byte index for the copy |
| upd_data | input | 8 | Time byte value for the copy |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-ended pulse |
| irq_suppress | input | 1 | Blocks interrupt assertion |
| irq | output | 1 | Level interrupt request |
| ctr_load | output | 1 | Reload request to the counter |
| ctr_time | output | 56 | Time bytes for the reload |

## Verification
The host read of the flag byte and a new enabled event can fall in the same cycle. Clear-on-read and flag-set then compete for the same byte and for the interrupt state. The bench provokes this by raising an alarm flag, then issuing the data-port read of byte 12 in the same cycle as a periodic pulse. It judges the result by three things: the returned value must be the old alarm flags, a second read must show only the periodic flags, and `irq` must stay high until that second read. A similar overlap between the update-in-progress bit and a host write to byte 10 is kept out of the random traffic.

// File: rtl/cmos_port_pkg.sv
package cmos_port_pkg;

    localparam int unsigned IX_CTRL_A = 10;
    localparam int unsigned IX_CTRL_B = 11;
    localparam int unsigned IX_FLAGS  = 12;
    localparam int unsigned IX_VALID  = 13;

    localparam logic [7:0] RST_CTRL_A = 8'h26;
    localparam logic [7:0] RST_CTRL_B = 8'h02;
    localparam logic [7:0] RST_FLAGS  = 8'h00;
    localparam logic [7:0] RST_VALID  = 8'h80;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    function automatic logic is_time_idx(input logic [7:0] ix);
        return (ix == 8'd0) || (ix == 8'd2) || (ix == 8'd4) ||
               (ix >= 8'd6 && ix <= 8'd9);
    endfunction

endpackage

// File: rtl/cmos_index_regs.sv
module cmos_index_regs #(
    parameter int IDXW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idx_we,
    input  logic            bank,
    input  logic [7:0]      wdata,
    output logic [IDXW-1:0] sel_idx
);
    logic [IDXW-1:0] idx_q [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q[b] <= '0;
            end else if (idx_we && (bank == 1'(b))) begin
                idx_q[b] <= {1'(b), wdata[IDXW-2:0]};
            end
        end
    end

    assign sel_idx = bank ? idx_q[1] : idx_q[0];

    // R1: the stored index always lands in the half picked by the bank bit
    a_r1_bank_half : assert property (@(posedge clk) disable iff (!rst_n)
        idx_we && bank |=> idx_q[1][IDXW-1]);
endmodule

// File: rtl/cmos_irq_fsm.sv
module cmos_irq_fsm
    import cmos_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clear,
    input  logic suppress,
    output logic irq_o
);
    irq_state_e state_q, state_d;
    logic raise_ok;

    assign raise_ok = raise && !suppress;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (raise_ok) state_d = IRQ_RAISED;
            IRQ_RAISED: if (clear && !raise_ok) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    // R11: a flag read with no fresh event drops the request
    a_r11_ack_drops : assert property (@(posedge clk) disable iff (!rst_n)
        clear && !raise |=> !irq_o);
    // R11: the level holds until acknowledged
    a_r11_level_holds : assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !clear |=> irq_o);
    // R12: a suppressed event never starts a request
    a_r12_suppress_blocks : assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && suppress |=> !irq_o);
    // R13: an event in the acknowledge cycle keeps the request up
    a_r13_event_wins : assert property (@(posedge clk) disable iff (!rst_n)
        raise && !suppress |=> irq_o);
endmodule

// File: rtl/cmos_host_port.sv
module cmos_host_port
    import cmos_port_pkg::*;
#(
    parameter int IDXW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_data,
    input  logic        upd_start,
    input  logic        upd_end,
    input  logic        upd_wr,
    input  logic [3:0]  upd_idx,
    input  logic [7:0]  upd_data,
    input  logic        evt_periodic,
    input  logic        evt_alarm,
    input  logic        evt_update,
    input  logic        irq_suppress,
    output logic        irq,
    output logic        ctr_load,
    output logic [55:0] ctr_time
);
    localparam int DEPTH = 1 << IDXW;
    localparam logic [IDXW-1:0] S_A = IDXW'(IX_CTRL_A);
    localparam logic [IDXW-1:0] S_B = IDXW'(IX_CTRL_B);
    localparam logic [IDXW-1:0] S_C = IDXW'(IX_FLAGS);
    localparam logic [IDXW-1:0] S_D = IDXW'(IX_VALID);

    logic [7:0]      mem [DEPTH];
    logic [IDXW-1:0] sel;
    logic            data_wr, data_rd, freeze, flag_rd, flag_set;
    logic [7:0]      new_flags;
    logic            load_d, load_q;
    logic [7:0]      rd_q;
    logic [7:0]      upd_full;

    assign data_wr = wr_en && addr[0];
    assign data_rd = rd_en && addr[0];
    assign freeze  = mem[S_B][7];
    assign upd_full = {4'h0, upd_idx};

    cmos_index_regs #(.IDXW(IDXW)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_we  (wr_en && !addr[0]),
        .bank    (addr[1]),
        .wdata   (wdata),
        .sel_idx (sel)
    );

    always_comb begin
        new_flags = 8'h00;
        if (evt_periodic && mem[S_B][6]) new_flags = new_flags | 8'hC0;
        if (evt_alarm    && mem[S_B][5]) new_flags = new_flags | 8'hA0;
        if (evt_update   && mem[S_B][4]) new_flags = new_flags | 8'h90;
    end

    assign flag_set = |new_flags;
    assign flag_rd  = data_rd && (sel == S_C);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            mem[S_A] <= RST_CTRL_A;
            mem[S_B] <= RST_CTRL_B;
            mem[S_C] <= RST_FLAGS;
            mem[S_D] <= RST_VALID;
        end else begin
            if (upd_start && !freeze) mem[S_A][7] <= 1'b1;
            if (upd_end)              mem[S_A][7] <= 1'b0;
            if (upd_wr && !freeze && is_time_idx(upd_full))
                mem[IDXW'(upd_idx)] <= upd_data;
            if (data_wr) begin
                unique case (sel)
                    S_A: mem[S_A] <= {mem[S_A][7], wdata[6:0]};
                    S_B: begin
                        mem[S_B] <= wdata;
                        if (wdata[7]) mem[S_A][7] <= 1'b0;
                    end
                    S_C, S_D: ;
                    default: mem[sel] <= wdata;
                endcase
            end
            mem[S_C] <= (flag_rd ? 8'h00 : mem[S_C]) | new_flags;
        end
    end

    always_comb begin
        load_d = 1'b0;
        if (data_wr) begin
            if (is_time_idx(8'(sel)) && !freeze) load_d = 1'b1;
            if (sel == S_B && !wdata[7] && freeze) load_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            rd_q   <= 8'h00;
        end else begin
            load_q <= load_d;
            if (rd_en) rd_q <= addr[0] ? mem[sel] : 8'hFF;
        end
    end

    cmos_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise    (flag_set),
        .clear    (flag_rd),
        .suppress (irq_suppress),
        .irq_o    (irq)
    );

    assign rd_data  = rd_q;
    assign ctr_load = load_q;
    assign ctr_time = {mem[9], mem[8], mem[7], mem[6], mem[4], mem[2], mem[0]};

    // R2: index port reads return all ones
    a_r2_index_read_ff : assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !addr[0] |=> rd_data == 8'hFF);
    // R4: byte 13 ignores host writes
    a_r4_valid_fixed : assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && sel == S_D |=> $stable(mem[S_D]));
    // R5: a host write to byte 10 leaves the progress bit alone
    a_r5_uip_kept : assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && sel == S_A && !upd_start && !upd_end |=> $stable(mem[S_A][7]));
    // R7, R8: every reload request follows a data-port write
    a_r8_load_source : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctr_load) |-> $past(data_wr));
    // R11: reading the flags leaves only fresh bits
    a_r11_flags_cleared : assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd && !flag_set |=> mem[S_C] == 8'h00);
endmodule

// File: tb/tb_cmos_host_port.sv
`timescale 1ns/1ps
module tb_cmos_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rd_data;
    logic        upd_start = 0, upd_end = 0, upd_wr = 0;
    logic [3:0]  upd_idx = '0;
    logic [7:0]  upd_data = '0;
    logic        evt_periodic = 0, evt_alarm = 0, evt_update = 0;
    logic        irq_suppress = 0;
    logic        irq, ctr_load;
    logic [55:0] ctr_time;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] mdl [256];

    always #4 clk = ~clk;

    cmos_host_port dut (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1;
        @(negedge clk); rd_en = 0; d = rd_data;
    endtask

    task automatic rd_reg(input logic [7:0] ix, output logic [7:0] d);
        wr(2'b00, ix);
        rd(2'b01, d);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: upd_start = 1;
            1: upd_end = 1;
            2: evt_periodic = 1;
            3: evt_alarm = 1;
            4: evt_update = 1;
            default: begin evt_periodic = 1; evt_alarm = 1; evt_update = 1; end
        endcase
        @(negedge clk);
        upd_start = 0; upd_end = 0; evt_periodic = 0; evt_alarm = 0; evt_update = 0;
    endtask

    function automatic logic [7:0] rand_plain_idx(input logic bank);
        if (bank) return 8'($urandom_range(0, 127));
        return 8'($urandom_range(14, 127));
    endfunction

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;

        chk("R3 irq after reset", irq, 0);
        rd_reg(8'd10, v); chk("R3 byte10", v, 8'h26);
        rd_reg(8'd11, v); chk("R3 byte11", v, 8'h02);
        rd_reg(8'd12, v); chk("R3 byte12", v, 8'h00);
        rd_reg(8'd13, v); chk("R3 byte13", v, 8'h80);

        rd(2'b00, v); chk("R2 bank0 index read", v, 8'hFF);
        rd(2'b10, v); chk("R2 bank1 index read", v, 8'hFF);

        wr(2'b00, 8'd13); wr(2'b01, 8'h12);
        rd(2'b01, v); chk("R4 byte13 write ignored", v, 8'h80);
        wr(2'b00, 8'd12); wr(2'b01, 8'h55);
        rd(2'b01, v); chk("R4 byte12 write ignored", v, 8'h00);

        pulse(0);
        rd_reg(8'd10, v); chk("R9 upd_start sets progress", v, 8'hA6);
        wr(2'b01, 8'h0F);
        rd(2'b01, v); chk("R5 progress bit kept", v, 8'h8F);
        pulse(1);
        rd(2'b01, v); chk("R9 upd_end clears progress", v, 8'h0F);
        wr(2'b01, 8'h26);

        pulse(0);
        wr(2'b00, 8'd11); wr(2'b01, 8'h82);
        rd_reg(8'd10, v); chk("R6 freeze clears progress", v, 8'h26);

        wr(2'b00, 8'd0); wr(2'b01, 8'h45);
        chk("R8 no load while frozen", ctr_load, 0);
        rd(2'b01, v); chk("R8 time byte stored", v, 8'h45);

        wr(2'b00, 8'd11); wr(2'b01, 8'h02);
        chk("R7 unfreeze loads", ctr_load, 1);
        chk("R8 ctr_time seconds", ctr_time[7:0], 8'h45);
        wr(2'b01, 8'h02);
        chk("R7 no load without prior freeze", ctr_load, 0);

        wr(2'b00, 8'd2); wr(2'b01, 8'h30);
        chk("R8 time write loads", ctr_load, 1);
        chk("R8 ctr_time minutes", ctr_time[15:8], 8'h30);
        wr(2'b00, 8'd1); wr(2'b01, 8'h10);
        chk("R8 alarm byte no load", ctr_load, 0);

        @(negedge clk); upd_wr = 1; upd_idx = 4'd4; upd_data = 8'h11;
        @(negedge clk); upd_wr = 0;
        rd_reg(8'd4, v); chk("R9 copy back stored", v, 8'h11);
        wr(2'b00, 8'd11); wr(2'b01, 8'h82);
        @(negedge clk); upd_wr = 1; upd_idx = 4'd4; upd_data = 8'h22;
        @(negedge clk); upd_wr = 0;
        pulse(0);
        rd_reg(8'd4, v); chk("R9 copy back blocked by freeze", v, 8'h11);
        rd_reg(8'd10, v); chk("R9 progress blocked by freeze", v, 8'h26);
        wr(2'b00, 8'd11); wr(2'b01, 8'h02);

        pulse(5);
        chk("R10 disabled events no irq", irq, 0);
        rd_reg(8'd12, v); chk("R10 disabled events no flags", v, 8'h00);

        wr(2'b00, 8'd11); wr(2'b01, 8'h72);
        pulse(3);
        chk("R11 irq rises on alarm", irq, 1);
        wr(2'b00, 8'd12);
        chk("R11 irq holds before read", irq, 1);
        rd(2'b01, v); chk("R10 alarm flags", v, 8'hA0);
        chk("R11 irq drops on read", irq, 0);
        rd(2'b01, v); chk("R11 flags cleared", v, 8'h00);

        pulse(2); pulse(4);
        rd(2'b01, v); chk("R10 periodic and update flags", v, 8'hD0);

        irq_suppress = 1;
        pulse(4);
        chk("R12 suppressed irq", irq, 0);
        rd(2'b01, v); chk("R12 flags still set", v, 8'h90);
        irq_suppress = 0;

        pulse(3);
        @(negedge clk); addr = 2'b01; rd_en = 1; evt_periodic = 1;
        @(negedge clk); rd_en = 0; evt_periodic = 0;
        chk("R13 read returns old flags", rd_data, 8'hA0);
        chk("R13 irq stays high", irq, 1);
        rd(2'b01, v); chk("R13 only new flags remain", v, 8'hC0);
        chk("R13 irq drops after second read", irq, 0);

        wr(2'b10, 8'd12); wr(2'b11, 8'h5A);
        rd(2'b11, v); chk("R14 bank1 index 140 stored", v, 8'h5A);
        rd(2'b11, v); chk("R14 bank1 read no clear", v, 8'h5A);
        wr(2'b10, 8'h8C);
        rd(2'b11, v); chk("R1 index bit7 dropped", v, 8'h5A);
        rd(2'b01, v); chk("R1 bank0 index independent", v, 8'h00);

        for (int i = 0; i < 256; i++) mdl[i] = 8'hxx;
        for (int it = 0; it < 150; it++) begin
            logic bnk;
            logic [7:0] ix, d;
            bnk = 1'($urandom_range(0, 1));
            ix  = rand_plain_idx(bnk);
            d   = 8'($urandom());
            wr({bnk, 1'b0}, ix); wr({bnk, 1'b1}, d);
            mdl[{bnk, ix[6:0]}] = d;
            if (it % 3 == 0) begin
                logic [7:0] ix2;
                ix2 = rand_plain_idx(bnk);
                if (mdl[{bnk, ix2[6:0]}] !== 8'hxx) begin
                    wr({bnk, 1'b0}, ix2);
                    rd({bnk, 1'b1}, v);
                    chk("R1 random revisit", v, mdl[{bnk, ix2[6:0]}]);
                end
            end
            rd({bnk, 1'b0}, v); chk("R2 random index read", v, 8'hFF);
            wr({bnk, 1'b0}, ix);
            rd({bnk, 1'b1}, v); chk("R1 random readback", v, d);
        end

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule